// File: doc/BRIEF.md
# Single-Wire Bus Slot and Reset Timing Engine

This block is the timing core of a master on an open-drain single-wire bus. One request runs one bus operation: a reset with presence detection, a write slot for a 0 or a 1, or a read slot. The engine drives a pull-low enable for the exact length of each low phase. It then releases the line for the following recovery phases and samples the synchronized line level at a fixed offset within the slot. Byte assembly, device addressing and checksums belong to the logic above it.

Intervals are counted in microsecond units. The unit tick is derived from the system clock through the `CLK_PER_US` parameter. Every interval is multiplied by a runtime delay coefficient, which stretches the whole slot for slow or long buses. A request is a one-cycle `start` with an operation code and a data bit. Completion is a one-cycle `done` pulse. The returned bit and the presence flag hold their values until a later operation completes.

Top module: `ow_slot_engine`

## Requirements
- R1: A write-1 slot pulls the line low for 6 units and then keeps it released for 64 units before completing.
- R2: A write-0 slot pulls the line low for 60 units and then keeps it released for 10 units before completing.
- R3: A read slot pulls the line low for 6 units. It samples the line at the end of the next 9 released units and waits 55 more units before completing. `rx_bit` takes the sampled level.
- R4: A reset pulls the line low for 480 units and samples the line after 70 released units. It completes 410 units later. `presence` becomes 1 when the sample was low and 0 when it was high.
- R5: One unit is `CLK_PER_US` clock cycles. Every interval is multiplied by `dly_coef`, which is captured at the start. A coefficient of 0 acts as 1.
- R6: `op` selects the operation: 00 is reset, 01 is write, 10 is read and 11 is touch. A write returns `rx_bit` equal to `tx_bit`. A touch with `tx_bit`=1 is a read slot. A touch with `tx_bit`=0 is a write-0 slot that returns 0.
- R7: A `start` that arrives while `busy` is high is ignored, and so are changes on `op`, `tx_bit` and `dly_coef`. The running slot keeps its timing.
- R8: `done` is high for exactly one cycle, the first cycle in which `busy` is low again. `rx_bit` and `presence` change only in that cycle and otherwise hold.
- R9: After reset the line is released, and `busy`, `done`, `rx_bit` and `presence` are 0.
- R10: The line is pulled low only during the low phase of an operation. The low phase begins in the cycle after an accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle operation request |
| op | input | 2 | Operation code (see R6) |
| tx_bit | input | 1 | Data bit for write and touch |
| dly_coef | input | COEF_W | Interval multiplier, 0 treated as 1 |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_bit | output | 1 | Result bit of the last read, write or touch |
| presence | output | 1 | 1 when the last reset saw a device answer |
| bus_pull_low | output | 1 | Drive the bus line low when 1 |
| bus_sense | input | 1 | Raw bus line level |

## Verification
A wrong phase count or a wrong unit scale appears on `bus_pull_low` as an edge that comes early or late, at the first phase boundary it touches. With a coefficient above 1 such an error grows larger and is easier to see. A wrong slot kind or a bad sample point appears as a wrong `rx_bit` or `presence` in the `done` cycle. A controller that stays busy or leaves too early shows a missing or misplaced `done` pulse at the end of the slot. The bench compares the line, `busy`, `done` and both result flags against its own model on every cycle. Each such error is therefore reported in the cycle where it first appears.

// File: rtl/ow_pkg.sv
// Shared types and nominal slot timing for the single-wire slot engine.
// Assumes all nominal lengths fit in NOM_W bits.
package ow_pkg;

    localparam int NOM_W = 9;

    typedef enum logic [1:0] {
        OP_RESET = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_TOUCH = 2'b11
    } ow_op_e;

    typedef enum logic [1:0] {
        SK_RST,
        SK_W0,
        SK_W1,
        SK_RD
    } slot_kind_e;

    // Length of the driven-low phase, in units.
    function automatic logic [NOM_W-1:0] low_units(slot_kind_e k);
        case (k)
            SK_RST:  return NOM_W'(480);
            SK_W0:   return NOM_W'(60);
            default: return NOM_W'(6);
        endcase
    endfunction

    // Length of the released phase that ends at the sample point (or the slot end).
    function automatic logic [NOM_W-1:0] mid_units(slot_kind_e k);
        case (k)
            SK_RST:  return NOM_W'(70);
            SK_W0:   return NOM_W'(10);
            SK_W1:   return NOM_W'(64);
            default: return NOM_W'(9);
        endcase
    endfunction

    // Recovery length after the sample point.
    function automatic logic [NOM_W-1:0] tail_units(slot_kind_e k);
        case (k)
            SK_RST:  return NOM_W'(410);
            SK_RD:   return NOM_W'(55);
            default: return NOM_W'(0);
        endcase
    endfunction

    // True for slot kinds that sample the bus.
    function automatic logic samples_bus(slot_kind_e k);
        return (k == SK_RST) || (k == SK_RD);
    endfunction

endpackage

// File: rtl/ow_bus_sync.sv
// Multi-flop synchronizer for the raw bus level.
// Assumes the line idles high, so the flops reset to 1.
module ow_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sync_q;

    // Shift the raw level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[STAGES-2:0], din};
    end

    assign dout = sync_q[STAGES-1];
endmodule

// File: rtl/ow_phase_timer.sv
// Phase timer: it counts a loaded number of units, each CLK_PER_US cycles long.
// phase_last is high in the final cycle of the phase, so a phase of N units
// spans exactly N*CLK_PER_US cycles after the loading edge. Assumes N >= 1 on load.
module ow_phase_timer #(
    parameter int CLK_PER_US = 250,
    parameter int CNT_W      = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_units,
    output logic             phase_last
);
    localparam int PRE_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
    localparam logic [PRE_W-1:0] PRE_MAX = PRE_W'(CLK_PER_US - 1);

    logic [PRE_W-1:0] pre_q;
    logic [CNT_W-1:0] unit_q;
    logic             tick;

    assign tick       = (pre_q == PRE_MAX);
    assign phase_last = tick && (unit_q == CNT_W'(1));

    // Prescaler: restarts on every load and wraps once per unit.
    always_ff @(posedge clk) begin
        if (!rst_n)               pre_q <= '0;
        else if (load)            pre_q <= '0;
        else if (unit_q != '0)    pre_q <= tick ? '0 : pre_q + PRE_W'(1);
    end

    // Unit counter: counts the remaining units of the phase down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                      unit_q <= '0;
        else if (load)                   unit_q <= load_units;
        else if (tick && unit_q != '0)   unit_q <= unit_q - CNT_W'(1);
    end
endmodule

// File: rtl/ow_slot_ctrl.sv
// Slot sequencer: it walks the low, released and recovery phases of one
// operation, samples the bus at the end of the released phase, and publishes
// the result with a single-cycle done. Assumes the phase timer reports the last
// cycle of each loaded phase.
module ow_slot_ctrl
    import ow_pkg::*;
#(
    parameter int COEF_W = 4,
    parameter int CNT_W  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic              tx_bit,
    input  logic [COEF_W-1:0] dly_coef,
    input  logic              sense_sync,
    input  logic              phase_last,
    output logic              load,
    output logic [CNT_W-1:0]  load_units,
    output logic              busy,
    output logic              done,
    output logic              rx_bit,
    output logic              presence,
    output logic              pull_low
);
    typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_MID, ST_TAIL} st_e;

    st_e               state_q, state_d;
    slot_kind_e        kind_q, new_kind;
    logic [COEF_W-1:0] coef_q, coef_eff;
    logic              sample_q;
    logic              finish;

    function automatic logic [CNT_W-1:0] scale(logic [NOM_W-1:0] u, logic [COEF_W-1:0] c);
        return CNT_W'(u) * CNT_W'(c);
    endfunction

    // Decode the request into a slot kind and an effective coefficient.
    always_comb begin
        case (ow_op_e'(op))
            OP_RESET: new_kind = SK_RST;
            OP_WRITE: new_kind = tx_bit ? SK_W1 : SK_W0;
            OP_READ:  new_kind = SK_RD;
            default:  new_kind = tx_bit ? SK_RD : SK_W0;
        endcase
        coef_eff = (dly_coef == '0) ? COEF_W'(1) : dly_coef;
    end

    // Next-state logic and phase loading.
    always_comb begin
        state_d    = state_q;
        load       = 1'b0;
        load_units = '0;
        finish     = 1'b0;
        case (state_q)
            ST_IDLE: if (start) begin
                load       = 1'b1;
                load_units = scale(low_units(new_kind), coef_eff);
                state_d    = ST_LOW;
            end
            ST_LOW: if (phase_last) begin
                load       = 1'b1;
                load_units = scale(mid_units(kind_q), coef_q);
                state_d    = ST_MID;
            end
            ST_MID: if (phase_last) begin
                if (samples_bus(kind_q)) begin
                    load       = 1'b1;
                    load_units = scale(tail_units(kind_q), coef_q);
                    state_d    = ST_TAIL;
                end else begin
                    finish  = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            default: if (phase_last) begin
                finish  = 1'b1;
                state_d = ST_IDLE;
            end
        endcase
    end

    // State register and per-operation captures.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            kind_q   <= SK_RST;
            coef_q   <= COEF_W'(1);
            sample_q <= 1'b1;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start) begin
                kind_q <= new_kind;
                coef_q <= coef_eff;
            end
            if (state_q == ST_MID && phase_last) sample_q <= sense_sync;
        end
    end

    // Result registers, updated only when an operation finishes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done     <= 1'b0;
            rx_bit   <= 1'b0;
            presence <= 1'b0;
        end else begin
            done <= finish;
            if (finish) begin
                case (kind_q)
                    SK_RST:  presence <= ~sample_q;
                    SK_RD:   rx_bit   <= sample_q;
                    SK_W0:   rx_bit   <= 1'b0;
                    default: rx_bit   <= 1'b1;
                endcase
            end
        end
    end

    assign busy     = (state_q != ST_IDLE);
    assign pull_low = (state_q == ST_LOW);
endmodule

// File: rtl/ow_slot_engine.sv
// Top of the single-wire slot engine: a bus synchronizer, a unit-paced phase
// timer and the slot sequencer. Assumes bus_sense is asynchronous to clk and
// that an external open-drain pad turns bus_pull_low into a low drive.
module ow_slot_engine #(
    parameter int CLK_PER_US = 250,
    parameter int COEF_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic              tx_bit,
    input  logic [COEF_W-1:0] dly_coef,
    output logic              busy,
    output logic              done,
    output logic              rx_bit,
    output logic              presence,
    output logic              bus_pull_low,
    input  logic              bus_sense
);
    localparam int CNT_W = ow_pkg::NOM_W + COEF_W;

    logic             sense_sync;
    logic             phase_last;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_units;

    ow_bus_sync #(.STAGES(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (bus_sense),
        .dout (sense_sync)
    );

    ow_phase_timer #(.CLK_PER_US(CLK_PER_US), .CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (tmr_load),
        .load_units(tmr_units),
        .phase_last(phase_last)
    );

    ow_slot_ctrl #(.COEF_W(COEF_W), .CNT_W(CNT_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .op        (op),
        .tx_bit    (tx_bit),
        .dly_coef  (dly_coef),
        .sense_sync(sense_sync),
        .phase_last(phase_last),
        .load      (tmr_load),
        .load_units(tmr_units),
        .busy      (busy),
        .done      (done),
        .rx_bit    (rx_bit),
        .presence  (presence),
        .pull_low  (bus_pull_low)
    );
endmodule

// File: rtl/ow_slot_engine_chk.sv
// Port-level protocol checker for ow_slot_engine, attached with bind.
module ow_slot_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic rx_bit,
    input logic presence,
    input logic bus_pull_low
);
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_at_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    assert_busy_fall_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_rx_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(rx_bit));

    assert_presence_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(presence));

    assert_low_starts_on_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_pull_low) |-> ($past(start) && !$past(busy)));

    assert_pull_only_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_pull_low |-> busy);

    assert_done_released_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !bus_pull_low);
endmodule

bind ow_slot_engine ow_slot_engine_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .busy        (busy),
    .done        (done),
    .rx_bit      (rx_bit),
    .presence    (presence),
    .bus_pull_low(bus_pull_low)
);

// File: tb/ow_slot_engine_tb.sv
// Bench for ow_slot_engine: a behavioural cycle model (queue of expected
// line levels) compared with the ports on every cycle.
module ow_slot_engine_tb;
    localparam int CPU    = 4;
    localparam int COEF_W = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [1:0]        op = 2'b00;
    logic              tx_bit = 1'b0;
    logic [COEF_W-1:0] dly_coef = 4'd1;
    logic              busy, done, rx_bit, presence, bus_pull_low;
    logic              slave_low = 1'b0;
    logic              bus_sense;

    int    checks = 0;
    int    errors = 0;
    int    cyc = 0;
    string cur_tag = "R9";

    int exp_q[$];
    bit m_done = 0, m_rx = 0, m_pres = 0;
    bit p_is_rst = 0, p_val = 0;

    always #2 clk = ~clk;

    assign bus_sense = ~(bus_pull_low | slave_low);

    ow_slot_engine #(.CLK_PER_US(CPU), .COEF_W(COEF_W)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .op          (op),
        .tx_bit      (tx_bit),
        .dly_coef    (dly_coef),
        .busy        (busy),
        .done        (done),
        .rx_bit      (rx_bit),
        .presence    (presence),
        .bus_pull_low(bus_pull_low),
        .bus_sense   (bus_sense)
    );

    task automatic push_n(int v, int n);
        for (int i = 0; i < n; i++) exp_q.push_back(v);
    endtask

    // Reference model: one queue entry per cycle of the running operation.
    always @(posedge clk) begin
        if (!rst_n) begin
            exp_q.delete();
            m_done = 0; m_rx = 0; m_pres = 0;
        end else begin
            m_done = 0;
            if (exp_q.size() > 0) begin
                void'(exp_q.pop_front());
                if (exp_q.size() == 0) begin
                    m_done = 1;
                    if (p_is_rst) m_pres = p_val;
                    else          m_rx   = p_val;
                end
            end else if (start) begin
                int k;
                int lo, mi, tl;
                k = (dly_coef == 0) ? 1 : int'(dly_coef);
                p_is_rst = 0;
                if (op == 2'b00) begin
                    lo = 480; mi = 70; tl = 410; p_is_rst = 1; p_val = slave_low;
                end else if (op == 2'b10 || (op == 2'b11 && tx_bit)) begin
                    lo = 6; mi = 9; tl = 55; p_val = ~slave_low;
                end else if (tx_bit && op == 2'b01) begin
                    lo = 6; mi = 64; tl = 0; p_val = 1;
                end else begin
                    lo = 60; mi = 10; tl = 0; p_val = 0;
                end
                push_n(1, lo * k * CPU);
                push_n(0, (mi + tl) * k * CPU);
            end
        end
    end

    task automatic chk(string tag, string what, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s got %0d expected %0d (cycle %0d)", tag, what, got, exp, cyc);
        end
    endtask

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(cur_tag, "bus_pull_low", bus_pull_low, (exp_q.size() > 0) ? exp_q[0] : 0);
            chk(cur_tag, "busy", busy, exp_q.size() > 0);
            chk(cur_tag, "done", done, m_done);
            chk(cur_tag, "rx_bit", rx_bit, m_rx);
            chk(cur_tag, "presence", presence, m_pres);
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic run_op(logic [1:0] o, logic d, int c, logic sl, string tag);
        @(negedge clk);
        slave_low = sl; cur_tag = tag;
        op = o; tx_bit = d; dly_coef = COEF_W'(c); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
        cur_tag = "R10";
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9", "reset outputs", {bus_pull_low, busy, done, rx_bit, presence}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        run_op(2'b01, 1'b1, 1, 1'b0, "R1");   // write-1
        run_op(2'b01, 1'b0, 1, 1'b0, "R2");   // write-0
        run_op(2'b10, 1'b0, 1, 1'b0, "R3");   // read, line high -> 1
        run_op(2'b10, 1'b1, 1, 1'b1, "R3");   // read, device holds low -> 0
        run_op(2'b00, 1'b0, 1, 1'b1, "R4");   // reset with presence
        run_op(2'b00, 1'b0, 1, 1'b0, "R4");   // reset, no device
        run_op(2'b11, 1'b1, 1, 1'b0, "R6");   // touch 1 acts as read -> 1
        run_op(2'b11, 1'b0, 1, 1'b0, "R6");   // touch 0 -> write-0, returns 0
        run_op(2'b01, 1'b1, 1, 1'b0, "R6");   // write returns data bit
        run_op(2'b01, 1'b1, 3, 1'b0, "R5");   // coefficient 3
        run_op(2'b00, 1'b0, 3, 1'b1, "R5");   // reset stretched
        run_op(2'b01, 1'b0, 0, 1'b0, "R5");   // coefficient 0 acts as 1
        run_op(2'b10, 1'b0, 2, 1'b1, "R5");   // read stretched

        // R7: start and input changes during a running read are ignored
        @(negedge clk);
        cur_tag = "R7"; slave_low = 1'b0;
        op = 2'b10; tx_bit = 1'b0; dly_coef = 4'd1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        op = 2'b00; tx_bit = 1'b1; dly_coef = 4'd9; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (40) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);

        // R8: outputs hold while idle inputs wiggle without start
        cur_tag = "R8";
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            op = 2'(i); tx_bit = i[0]; slave_low = i[1];
        end
        slave_low = 1'b0;
        repeat (5) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule